// File: doc/BRIEF.md
# Stepped Power-Down Output Divider

This block divides a high-rate clock down to an output clock with a 50% duty cycle. A 2-bit ratio code gives a base divide of 1, 2, 4 or 8. A power-down request adds a further divide by 16. The extra factor is not switched in one move. It ramps through binary steps, and a slower reference clock paces the steps. The output frequency therefore moves gently when power-down is entered and again when it is left.

The reference-clock domain holds a step exponent from 0 to 4. On each reference edge it moves one place toward the synchronized power-down request. The exponent crosses into the fast domain as a Gray code through a two-flop synchronizer. In the fast domain, a tracker moves its applied exponent one place toward that value, and only at an output period boundary. The effective ratio is the base ratio times 2 to the power of the applied exponent, with a maximum of 128. At an overall ratio of 1, the fast clock passes straight through to the output.

Top module: `pd_step_div`

## Requirements
- R1: While `rst_n` is low at clock edges, `step_o` reads 0 and the divider counters clear. After release, the output runs at the base ratio.
- R2: With `step_o` at 0, `rat_code` values 0, 1, 2 and 3 give output periods of 1, 2, 4 and 8 fast-clock cycles (ratio = 2^code).
- R3: Every output period has a high phase equal to its low phase, at every ratio including 1.
- R4: While `pwr_down` is held high, the ratio steps through base×2, ×4, ×8 and ×16, and `step_o` settles at 4.
- R5: After `pwr_down` falls, the ratio returns to the base ratio in four halving steps, and `step_o` settles at 0.
- R6: `step_o` changes by exactly one whenever it changes, and it never exceeds 4.
- R7: A new ratio, whether from `rat_code` or from a step, takes effect only at the start of a high phase. So `rat_code` changes made during power-down show up at the next boundary as base×16.
- R8: The reference-domain exponent moves by at most one per reference edge, and only toward the synchronized request. A full entry ramp therefore takes at least four reference periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | High-rate source clock |
| clk_ref | input | 1 | Slow reference clock that paces the steps |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| rat_code | input | 2 | Base ratio exponent (ratio 1, 2, 4, 8) |
| pwr_down | input | 1 | Request for the extra divide by 16 |
| clk_out | output | 1 | Divided output clock |
| step_o | output | 3 | Applied extra-factor exponent, 0 to 4 |

## Verification
A bad divider count or a bad phase register shows up within one output period as a high phase that differs from its low phase, or as a period length that does not match the expected ratio. A fault in the step tracker or the Gray crossing appears as a skipped or out-of-order ratio in the ramp, or as a jump of more than one in `step_o`. It appears on the first boundary after the fault. A fault in reference pacing shows up as a ramp that finishes in fewer than four reference periods, or as a ramp that never ends.

// File: rtl/pd_step_pkg.sv
// Package: shared sizes and Gray helpers for the stepped power-down divider.
// Assumes the step exponent fits in 8 bits; the helpers work on that width.
package pd_step_pkg;
    localparam int unsigned GRAY_MAX_W = 8;

    // Converts a binary value to its reflected Gray code.
    function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Converts a reflected Gray code back to binary.
    function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/pd_ramp_seq.sv
// Reference-domain sequencer. It synchronizes the power-down request and moves
// a step exponent one place per reference edge toward 0 or STEP_MAX.
// It publishes the exponent as a registered Gray code.
// Assumes rst_n is held low across several reference edges.
module pd_ramp_seq
    import pd_step_pkg::*;
#(
    parameter int unsigned STEP_MAX    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned STEP_W     = $clog2(STEP_MAX + 1)
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              pwr_down,
    output logic              pd_sync,
    output logic [STEP_W-1:0] step_bin,
    output logic [STEP_W-1:0] step_gray
);
    logic [SYNC_STAGES-1:0] pd_pipe;
    logic [STEP_W-1:0]      step_q;
    logic [GRAY_MAX_W-1:0]  gray_wide;

    assign gray_wide = to_gray(GRAY_MAX_W'(step_q));

    // Brings the asynchronous request into the reference domain.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) pd_pipe <= '0;
        else        pd_pipe <= {pd_pipe[SYNC_STAGES-2:0], pwr_down};
    end

    assign pd_sync = pd_pipe[SYNC_STAGES-1];

    // Moves the exponent by one toward the synchronized request.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)                                    step_q <= '0;
        else if (pd_sync && step_q < STEP_W'(STEP_MAX)) step_q <= step_q + 1'b1;
        else if (!pd_sync && step_q != '0)             step_q <= step_q - 1'b1;
    end

    // Registers the Gray form so that only one bit changes per edge.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) step_gray <= '0;
        else        step_gray <= gray_wide[STEP_W-1:0];
    end

    assign step_bin = step_q;
endmodule

// File: rtl/step_gray_sync.sv
// Fast-domain receiver for the Gray-coded step. It runs the code through a
// flop chain and decodes it to binary.
// Assumes the source changes by at most one code per reference edge.
module step_gray_sync
    import pd_step_pkg::*;
#(
    parameter int unsigned STEP_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] gray_in,
    output logic [STEP_W-1:0] step_target
);
    logic [STEP_W-1:0]     stage [SYNC_STAGES];
    logic [GRAY_MAX_W-1:0] dec_wide;

    // First stage captures the crossing code.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= gray_in;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        // Further stages let metastability settle.
        always_ff @(posedge clk_fast) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign dec_wide    = from_gray(GRAY_MAX_W'(stage[SYNC_STAGES-1]));
    assign step_target = dec_wide[STEP_W-1:0];
endmodule

// File: rtl/ramp_out_div.sv
// Fast-domain output divider. It holds an applied step exponent and a ratio
// exponent. Both change only at a period boundary, which is the start of a
// high phase. At ratio 1 the source clock is passed straight through.
// Assumes rat_code is quasi-static and step_target moves by one at a time.
module ramp_out_div #(
    parameter int unsigned N_W      = 2,
    parameter int unsigned STEP_MAX = 4,
    localparam int unsigned STEP_W  = $clog2(STEP_MAX + 1),
    localparam int unsigned MAX_LOG = (1 << N_W) - 1 + STEP_MAX,
    localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1),
    localparam int unsigned CNT_W   = (MAX_LOG > 1) ? MAX_LOG - 1 : 1
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [N_W-1:0]    rat_code,
    input  logic [STEP_W-1:0] step_target,
    output logic              clk_out,
    output logic [STEP_W-1:0] step_applied,
    output logic [LOG_W-1:0]  ratio_log2,
    output logic              div_phase,
    output logic              bypass
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  half_m1;
    logic [STEP_W-1:0] step_next;
    logic [LOG_W-1:0]  log_next;
    logic              boundary;

    // Half-period length minus one for the current ratio.
    always_comb begin
        if (ratio_log2 == '0) half_m1 = '0;
        else half_m1 = (CNT_W'(1) << (ratio_log2 - LOG_W'(1))) - CNT_W'(1);
    end

    // A period ends on the cycle before a low phase would turn high.
    assign boundary = bypass || (!div_phase && cnt_q == half_m1);

    // Next applied exponent, one place toward the target.
    always_comb begin
        if (step_target > step_applied)      step_next = step_applied + 1'b1;
        else if (step_target < step_applied) step_next = step_applied - 1'b1;
        else                                 step_next = step_applied;
    end

    assign log_next = LOG_W'(rat_code) + LOG_W'(step_next);

    // Half-period counter and phase, reloaded at each boundary.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            div_phase    <= 1'b0;
            bypass       <= 1'b1;
            ratio_log2   <= '0;
            step_applied <= '0;
        end else if (boundary) begin
            step_applied <= step_next;
            ratio_log2   <= log_next;
            cnt_q        <= '0;
            bypass       <= (log_next == '0);
            div_phase    <= (log_next != '0);
        end else if (cnt_q == half_m1) begin
            cnt_q     <= '0;
            div_phase <= ~div_phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clk_out = bypass ? clk_fast : div_phase;
endmodule

// File: rtl/pd_step_div.sv
// Top of the stepped power-down divider. It ties together the reference-domain
// sequencer, the Gray crossing and the fast-domain divider.
// Assumes rst_n is held low across edges of both clocks.
module pd_step_div #(
    parameter int unsigned N_W         = 2,
    parameter int unsigned STEP_MAX    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_fast,
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [1:0] rat_code,
    input  logic       pwr_down,
    output logic       clk_out,
    output logic [2:0] step_o
);
    localparam int unsigned STEP_W  = $clog2(STEP_MAX + 1);
    localparam int unsigned MAX_LOG = (1 << N_W) - 1 + STEP_MAX;
    localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

    logic              pd_ref;
    logic [STEP_W-1:0] step_ref;
    logic [STEP_W-1:0] step_gray;
    logic [STEP_W-1:0] step_target;
    logic [STEP_W-1:0] step_applied;
    logic [LOG_W-1:0]  ratio_log2;
    logic              div_phase;
    logic              bypass;

    pd_ramp_seq #(.STEP_MAX(STEP_MAX), .SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .pd_sync  (pd_ref),
        .step_bin (step_ref),
        .step_gray(step_gray)
    );

    step_gray_sync #(.STEP_W(STEP_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .gray_in    (step_gray),
        .step_target(step_target)
    );

    ramp_out_div #(.N_W(N_W), .STEP_MAX(STEP_MAX)) u_div (
        .clk_fast    (clk_fast),
        .rst_n       (rst_n),
        .rat_code    (N_W'(rat_code)),
        .step_target (step_target),
        .clk_out     (clk_out),
        .step_applied(step_applied),
        .ratio_log2  (ratio_log2),
        .div_phase   (div_phase),
        .bypass      (bypass)
    );

    assign step_o = 3'(step_applied);
endmodule

// File: rtl/pd_step_div_chk.sv
// Checker for the stepped power-down divider, bound into the top module.
// Assumes the default parameter set (step exponent limit 4).
module pd_step_div_chk (
    input logic       clk_fast,
    input logic       clk_ref,
    input logic       rst_n,
    input logic [2:0] step_o,
    input logic [2:0] step_ref,
    input logic       pd_ref,
    input logic [2:0] ratio_log2,
    input logic       div_phase,
    input logic       bypass
);
    // R1: reset clears the applied step.
    p_reset_step_r1: assert property (@(posedge clk_fast)
        !rst_n |=> step_o == 3'd0);

    // R6: applied step stays in range.
    p_step_range_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        step_o <= 3'd4);

    // R6: applied step moves by exactly one.
    p_step_unit_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        step_o != $past(step_o) |->
            (step_o == $past(step_o) + 3'd1 || step_o + 3'd1 == $past(step_o)));

    // R7: a ratio change lands at the start of a high phase or in pass-through.
    p_ratio_at_boundary_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(ratio_log2) |-> (div_phase || bypass));

    // R8: the reference step does not fall while the request is high.
    p_ref_no_fall_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        pd_ref |=> step_ref >= $past(step_ref));

    // R8: the reference step moves by at most one per edge.
    p_ref_unit_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        step_ref != $past(step_ref) |->
            (step_ref == $past(step_ref) + 3'd1 || step_ref + 3'd1 == $past(step_ref)));
endmodule

bind pd_step_div pd_step_div_chk chk_i (
    .clk_fast  (clk_fast),
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .step_o    (step_o),
    .step_ref  (step_ref),
    .pd_ref    (pd_ref),
    .ratio_log2(ratio_log2),
    .div_phase (div_phase),
    .bypass    (bypass)
);

// File: tb/pd_step_div_tb_top.sv
// Scoreboard bench: the driver queues each distinct ratio it expects. The
// monitor measures each output period in half-cycles and pops on every change.
module pd_step_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 370;
    localparam int WATCHDOG   = 180000 * CLK_PERIOD;

    logic       clk_fast = 1'b0;
    logic       clk_ref  = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] rat_code = 2'd0;
    logic       pwr_down = 1'b0;
    logic       clk_out;
    logic [2:0] step_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit mon_en   = 1'b0;
    int exp_q[$];

    pd_step_div dut_i (
        .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n),
        .rat_code(rat_code), .pwr_down(pwr_down),
        .clk_out(clk_out), .step_o(step_o)
    );

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;
    always #(REF_PERIOD/2) clk_ref  = ~clk_ref;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Monitor: half-cycle samples, period measurement, and popping from the scoreboard.
    initial begin
        bit lvl, armed, have_high, s;
        int run, high_len, last_ratio;
        armed = 0; have_high = 0; run = 0; high_len = 0; last_ratio = -1; lvl = 0;
        wait (mon_en);
        @(clk_fast); #1; lvl = clk_out; run = 1;
        forever begin
            @(clk_fast); #1;
            s = clk_out;
            if (s == lvl) run++;
            else begin
                if (lvl) begin
                    high_len = run;
                    have_high = armed;
                end else begin
                    if (have_high) begin
                        check(high_len == run, "R3 duty", run, high_len);
                        if (high_len != last_ratio) begin
                            if (exp_q.size() == 0)
                                check(1'b0, "R7 unexpected ratio", high_len, -1);
                            else
                                check(high_len == exp_q[0], "R2/R4/R5/R7 ratio order",
                                      high_len, exp_q[0]);
                            if (exp_q.size() != 0) void'(exp_q.pop_front());
                            last_ratio = high_len;
                        end
                    end
                    armed = 1;
                end
                lvl = s; run = 1;
            end
        end
    end

    // Monitor: each change of the step status is a unit move.
    initial begin
        logic [2:0] prev;
        wait (mon_en);
        @(negedge clk_fast); prev = step_o;
        forever begin
            @(negedge clk_fast);
            if (step_o != prev) begin
                check(step_o == prev + 3'd1 || step_o + 3'd1 == prev, "R6 unit step",
                      int'(step_o), int'(prev));
                check(step_o <= 3'd4, "R6 step range", int'(step_o), 4);
                prev = step_o;
            end
        end
    end

    initial begin
        #(WATCHDOG);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // Driver: queue expectations, then apply stimulus.
    initial begin
        time t0;
        repeat (4) @(posedge clk_ref);
        @(negedge clk_fast);
        check(step_o == 3'd0, "R1 reset step", int'(step_o), 0);
        exp_q.push_back(1);
        rst_n = 1'b1;
        mon_en = 1'b1;
        #(3000);
        check(step_o == 3'd0, "R1 after release", int'(step_o), 0);

        // R2: each base ratio.
        for (int c = 1; c < 4; c++) begin
            exp_q.push_back(1 << c);
            rat_code = 2'(c);
            #(3000);
        end

        // R4 and R8: entry ramp with rat_code 3.
        exp_q.push_back(16); exp_q.push_back(32); exp_q.push_back(64); exp_q.push_back(128);
        t0 = $time;
        pwr_down = 1'b1;
        while (step_o != 3'd4 && $time - t0 < 40000) @(negedge clk_fast);
        check(($time - t0) >= 4 * REF_PERIOD, "R8 ramp pacing", int'($time - t0), 4 * REF_PERIOD);
        #(6000);
        check(step_o == 3'd4, "R4 step settles", int'(step_o), 4);

        // R7: base ratio change during power-down.
        exp_q.push_back(32);
        rat_code = 2'd1;
        #(6000);

        // R5: exit ramp.
        exp_q.push_back(16); exp_q.push_back(8); exp_q.push_back(4); exp_q.push_back(2);
        pwr_down = 1'b0;
        #(15000);
        check(step_o == 3'd0, "R5 step returns", int'(step_o), 0);

        // R4 and R5 with pass-through base ratio.
        exp_q.push_back(1);
        rat_code = 2'd0;
        #(3000);
        exp_q.push_back(2); exp_q.push_back(4); exp_q.push_back(8); exp_q.push_back(16);
        pwr_down = 1'b1;
        #(8000);
        check(step_o == 3'd4, "R4 step at limit", int'(step_o), 4);
        exp_q.push_back(8); exp_q.push_back(4); exp_q.push_back(2); exp_q.push_back(1);
        pwr_down = 1'b0;
        #(8000);
        check(step_o == 3'd0, "R5 step back to zero", int'(step_o), 0);
        check(exp_q.size() == 0, "R7 all ratios seen", exp_q.size(), 0);
        finish_run();
    end
endmodule